// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a stereo serial audio stream into parallel left and right samples for a playback path. It is a clock slave. The bit clock, the word/frame clock and the serial data all arrive as asynchronous inputs. A faster system clock synchronizes them, detects bit-clock rising edges and shifts the data in, most significant bit first. Data is taken on each rising edge of the bit clock.

A static format input selects one of four framings:

- I²S: the word is delayed by one bit.
- Left-justified: the word starts at the word-clock edge.
- Right-justified: the word ends at the next word-clock edge.
- Packed DSP: a frame-sync pulse opens two back-to-back words.

A word-length input selects 16, 18, 20 or 24 bits. Each sample is placed MSB-justified in a 24-bit output word. A one-cycle strobe marks each completed stereo frame, and both sample outputs update together with it.

Top module: `serial_audio_rx`

## Requirements
- R1: While rst_ni is low, and after it rises until the first completed frame, left_o and right_o are zero and valid_o is low.
- R2: With fmt_i = 0 (I²S), the MSB of a word is taken on the second bit-clock rise after a word-clock change. Word clock low carries left and high carries right.
- R3: With fmt_i = 1 (left-justified), the MSB of a word is taken on the first bit-clock rise that sees the new word-clock level. Word clock high carries left.
- R4: With fmt_i = 2 (right-justified), the LSB of a word is the last bit taken before the word clock changes. The word is the wl most recent bits, and it is assigned to the channel of the level that just ended: high means left.
- R5: With fmt_i = 3 (DSP), a word-clock rise is a frame sync. The first bit-clock rise that sees it high carries the left MSB, and the right MSB comes on the bit-clock rise right after the left LSB, with no gap.
- R6: wl_sel_i selects the word length: 0 = 16, 1 = 18, 2 = 20, 3 = 24 bits. The received word appears MSB-justified in the 24-bit outputs, and the unused low bits are zero.
- R7: valid_o goes high for exactly one system cycle per frame, after the right word, and only if a left word was captured before it in the same frame.
- R8: left_o and right_o change only in a cycle where valid_o is high.
- R9: The block works with free-running bit and word clocks that are unrelated in phase to clk_i, provided clk_i runs at least four times the bit-clock rate. valid_o follows the captured bit-clock rise by two system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial bit clock (asynchronous) |
| ws_i | input | 1 | Word clock / frame sync (asynchronous) |
| sd_i | input | 1 | Serial data, MSB first |
| fmt_i | input | 2 | Framing: 0 I²S, 1 left-justified, 2 right-justified, 3 DSP |
| wl_sel_i | input | 2 | Word length: 0=16, 1=18, 2=20, 3=24 bits |
| left_o | output | 24 | Left sample, MSB-justified |
| right_o | output | 24 | Right sample, MSB-justified |
| valid_o | output | 1 | One-cycle strobe per completed stereo frame |

## Verification
The assertions assume the following about the inputs:

- fmt_i and wl_sel_i change only while reset is held.
- Word clock and data change only around bit-clock falling edges, so they are settled at the sampled rising edge.
- Each bit-clock level lasts at least two system cycles.

The bench changes format and word length only inside a reset pulse and drives word clock and data together with the falling edge. It runs the bit clock at half-periods of 33 ns and 17 ns against an 8 ns system clock. The 17 ns setting stays just above the four-to-one limit and keeps the phase drifting.

// File: rtl/serial_audio_rx_pkg.sv
package serial_audio_rx_pkg;

  localparam int unsigned CNT_W = 6;

  typedef enum logic [1:0] {
    FMT_I2S = 2'd0,
    FMT_LJ  = 2'd1,
    FMT_RJ  = 2'd2,
    FMT_DSP = 2'd3
  } fmt_e;

  function automatic logic [CNT_W-1:0] wl_len(input logic [1:0] sel);
    case (sel)
      2'd0:    return CNT_W'(16);
      2'd1:    return CNT_W'(18);
      2'd2:    return CNT_W'(20);
      default: return CNT_W'(24);
    endcase
  endfunction

endpackage

// File: rtl/sarx_sync.sv
module sarx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic ws_i,
  input  logic sd_i,
  output logic bit_evt_o,
  output logic ws_o,
  output logic sd_o
);

  localparam int unsigned NSIG = 3;

  logic [NSIG-1:0] raw;
  logic [NSIG-1:0] synced;
  logic            sclk_hist_q;

  assign raw = {sd_i, ws_i, sclk_i};

  for (genvar g = 0; g < NSIG; g++) begin : g_sync
    logic [STAGES-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else         q <= {q[STAGES-2:0], raw[g]};
    end
    assign synced[g] = q[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_hist_q <= 1'b0;
    else         sclk_hist_q <= synced[0];
  end

  assign bit_evt_o = synced[0] & ~sclk_hist_q;
  assign ws_o      = synced[1];
  assign sd_o      = synced[2];

endmodule

// File: rtl/sarx_deframe.sv
module sarx_deframe
  import serial_audio_rx_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bit_evt_i,
  input  logic                ws_i,
  input  logic                sd_i,
  input  fmt_e                fmt_i,
  input  logic [1:0]          wl_sel_i,
  output logic                cap_left_o,
  output logic                cap_right_o,
  output logic [SAMPLE_W-1:0] word_o
);

  logic                ws_prev_q, trans_d_q;
  logic [SAMPLE_W-1:0] sh_q;
  logic [CNT_W-1:0]    cnt_q;

  logic [CNT_W-1:0]    wl, limit, cnt_nx;
  logic                trans, start, hit_first, hit_last;
  logic [SAMPLE_W-1:0] word_now, word_sel;
  logic                cap_l, cap_r;

  assign wl       = wl_len(wl_sel_i);
  assign limit    = (fmt_i == FMT_DSP) ? {wl[CNT_W-2:0], 1'b0} : wl;
  assign trans    = ws_i ^ ws_prev_q;
  assign word_now = {sh_q[SAMPLE_W-2:0], sd_i};

  always_comb begin
    case (fmt_i)
      FMT_I2S: start = trans_d_q;
      FMT_LJ:  start = trans;
      FMT_DSP: start = ws_i & ~ws_prev_q;
      default: start = 1'b0;
    endcase
  end

  assign cnt_nx    = start ? CNT_W'(1) : ((cnt_q != '0) ? cnt_q + CNT_W'(1) : '0);
  assign hit_first = (cnt_nx == wl);
  assign hit_last  = (cnt_nx == limit) && (cnt_nx != '0);

  always_comb begin
    cap_l    = 1'b0;
    cap_r    = 1'b0;
    word_sel = word_now;
    case (fmt_i)
      FMT_I2S: begin
        cap_l = hit_first & ~ws_i;
        cap_r = hit_first &  ws_i;
      end
      FMT_LJ: begin
        cap_l = hit_first &  ws_i;
        cap_r = hit_first & ~ws_i;
      end
      FMT_RJ: begin
        // word ended on the previous bit; current bit belongs to the next half
        word_sel = sh_q;
        cap_l    = trans &  ws_prev_q;
        cap_r    = trans & ~ws_prev_q;
      end
      default: begin
        cap_l = hit_first & ~hit_last;
        cap_r = hit_last;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ws_prev_q   <= 1'b0;
      trans_d_q   <= 1'b0;
      sh_q        <= '0;
      cnt_q       <= '0;
      cap_left_o  <= 1'b0;
      cap_right_o <= 1'b0;
      word_o      <= '0;
    end else begin
      cap_left_o  <= 1'b0;
      cap_right_o <= 1'b0;
      if (bit_evt_i) begin
        ws_prev_q   <= ws_i;
        trans_d_q   <= trans;
        sh_q        <= word_now;
        cnt_q       <= hit_last ? '0 : cnt_nx;
        cap_left_o  <= cap_l;
        cap_right_o <= cap_r;
        word_o      <= word_sel;
      end
    end
  end

endmodule

// File: rtl/sarx_align.sv
module sarx_align
  import serial_audio_rx_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 24
) (
  input  logic [SAMPLE_W-1:0] word_i,
  input  logic [1:0]          wl_sel_i,
  output logic [SAMPLE_W-1:0] aligned_o
);

  logic [CNT_W-1:0] shamt;

  // shifting out the top discards bits older than the word
  assign shamt     = CNT_W'(SAMPLE_W) - wl_len(wl_sel_i);
  assign aligned_o = word_i << shamt;

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import serial_audio_rx_pkg::*;
#(
  parameter int unsigned SAMPLE_W    = 24,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sclk_i,
  input  logic                ws_i,
  input  logic                sd_i,
  input  logic [1:0]          fmt_i,
  input  logic [1:0]          wl_sel_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o
);

  logic                bit_evt, ws_s, sd_s;
  logic                cap_l, cap_r;
  logic [SAMPLE_W-1:0] word, aligned;
  logic [SAMPLE_W-1:0] left_hold_q;
  logic                left_got_q;

  sarx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sclk_i    (sclk_i),
    .ws_i      (ws_i),
    .sd_i      (sd_i),
    .bit_evt_o (bit_evt),
    .ws_o      (ws_s),
    .sd_o      (sd_s)
  );

  sarx_deframe #(.SAMPLE_W(SAMPLE_W)) u_deframe (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bit_evt_i   (bit_evt),
    .ws_i        (ws_s),
    .sd_i        (sd_s),
    .fmt_i       (fmt_e'(fmt_i)),
    .wl_sel_i    (wl_sel_i),
    .cap_left_o  (cap_l),
    .cap_right_o (cap_r),
    .word_o      (word)
  );

  sarx_align #(.SAMPLE_W(SAMPLE_W)) u_align (
    .word_i    (word),
    .wl_sel_i  (wl_sel_i),
    .aligned_o (aligned)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_hold_q <= '0;
      left_got_q  <= 1'b0;
      left_o      <= '0;
      right_o     <= '0;
      valid_o     <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (cap_l) begin
        left_hold_q <= aligned;
        left_got_q  <= 1'b1;
      end else if (cap_r) begin
        left_got_q <= 1'b0;
        if (left_got_q) begin
          left_o  <= left_hold_q;
          right_o <= aligned;
          valid_o <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/sarx_checker.sv
module sarx_checker #(
  parameter int unsigned SAMPLE_W = 24
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [1:0]          wl_sel_i,
  input logic                bit_evt,
  input logic                valid_o,
  input logic [SAMPLE_W-1:0] left_o,
  input logic [SAMPLE_W-1:0] right_o
);

  logic [SAMPLE_W-1:0] low_mask;
  always_comb begin
    case (wl_sel_i)
      2'd0:    low_mask = SAMPLE_W'(24'h0000FF);
      2'd1:    low_mask = SAMPLE_W'(24'h00003F);
      2'd2:    low_mask = SAMPLE_W'(24'h00000F);
      default: low_mask = '0;
    endcase
  end

  p_strobe_one_cycle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  p_hold_between_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(left_o) && $stable(right_o)));

  p_low_bits_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (((left_o & low_mask) == '0) && ((right_o & low_mask) == '0)));

  p_strobe_after_bit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(bit_evt, 2));

endmodule

bind serial_audio_rx sarx_checker #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wl_sel_i (wl_sel_i),
  .bit_evt  (bit_evt),
  .valid_o  (valid_o),
  .left_o   (left_o),
  .right_o  (right_o)
);

// File: tb/serial_audio_rx_tb.sv
module serial_audio_rx_tb;

  localparam int NFR = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sclk = 1'b0, ws = 1'b0, sd = 1'b0;
  logic [1:0]  fmt = 2'd0, wl_sel = 2'd0;
  logic [23:0] left_o, right_o;
  logic        valid_o;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [23:0] got_l [8];
  logic [23:0] got_r [8];
  int          got_n = 0;
  int          wide_pulse = 0, hold_viol = 0;
  logic        prev_valid = 1'b0;
  logic [23:0] prev_l = '0, prev_r = '0;

  always #4 clk = ~clk;

  serial_audio_rx u_dut (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .sclk_i   (sclk),
    .ws_i     (ws),
    .sd_i     (sd),
    .fmt_i    (fmt),
    .wl_sel_i (wl_sel),
    .left_o   (left_o),
    .right_o  (right_o),
    .valid_o  (valid_o)
  );

  always @(negedge clk) begin
    if (rst_ni) begin
      if (valid_o) begin
        if (got_n < 8) begin
          got_l[got_n] = left_o;
          got_r[got_n] = right_o;
        end
        got_n++;
        if (prev_valid) wide_pulse++;
      end else if (left_o != prev_l || right_o != prev_r) begin
        hold_viol++;
      end
    end
    prev_valid = valid_o;
    prev_l     = left_o;
    prev_r     = right_o;
  end

  function automatic int wbits(input int sel);
    case (sel)
      0: return 16;
      1: return 18;
      2: return 20;
      default: return 24;
    endcase
  endfunction

  function automatic logic [23:0] pat(input int m, input int w, input int f, input int ch);
    logic [31:0] v;
    case (f)
      0: v = 32'hFFFF_FFFF;
      1: v = (ch == 0) ? (32'd1 << (w - 1)) : 32'd1;
      default: begin
        v = 32'(f * 40503 + m * 7919 + w * 131 + ch * 977) * 32'h9E37_79B1;
        v = {8'd0, v[31:8]};
      end
    endcase
    return v[23:0] & ((24'd1 << w) - 24'd1);
  endfunction

  task automatic check(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic slot(input logic w, input logic d, input int half);
    sclk = 1'b0;
    ws   = w;
    sd   = d;
    #(half);
    sclk = 1'b1;
    #(half);
  endtask

  task automatic send_frame(input int m, input int w, input int f, input int half);
    logic [23:0] lw, rw;
    lw = pat(m, w, f, 0);
    rw = pat(m, w, f, 1);
    for (int s = 0; s < 64; s++) begin
      int h = s / 32;
      int k = s % 32;
      logic [23:0] word = (h == 0) ? lw : rw;
      logic wv, dv;
      case (m)
        0: begin wv = (h == 1); dv = (k >= 1 && k <= w) ? word[w - k] : 1'b0; end
        1: begin wv = (h == 0); dv = (k < w) ? word[w - 1 - k] : 1'b0; end
        2: begin wv = (h == 0); dv = (k >= 32 - w) ? word[31 - k] : 1'b0; end
        default: begin
          wv = (s == 0);
          if (s < w)          dv = lw[w - 1 - s];
          else if (s < 2 * w) dv = rw[2 * w - 1 - s];
          else                dv = 1'b0;
        end
      endcase
      slot(wv, dv, half);
    end
  endtask

  task automatic run_cfg(input int m, input int sel, input int half);
    int w = wbits(sel);
    int first = (m == 0) ? 1 : 0;
    string req;
    case (m)
      0: req = "R2";
      1: req = "R3";
      2: req = "R4";
      default: req = "R5";
    endcase
    if (half < 20) req = {req, "/R9"};
    rst_ni = 1'b0;
    sclk = 1'b0; ws = 1'b0; sd = 1'b0;
    fmt = 2'(m);
    wl_sel = 2'(sel);
    repeat (3) @(posedge clk);
    #1;
    got_n = 0;
    rst_ni = 1'b1;
    repeat (2) @(posedge clk);
    for (int f = 0; f < NFR; f++) send_frame(m, w, f, half);
    slot((m == 1 || m == 2) ? 1'b1 : 1'b0, 1'b0, half);
    sclk = 1'b0;
    repeat (20) @(posedge clk);
    @(negedge clk);
    check(got_n == NFR - first, {req, " frame count"}, 24'(got_n), 24'(NFR - first));
    for (int f = first; f < NFR; f++) begin
      int i = f - first;
      logic [23:0] el = pat(m, w, f, 0) << (24 - w);
      logic [23:0] er = pat(m, w, f, 1) << (24 - w);
      if (i < got_n && i < 8) begin
        check(got_l[i] == el, {req, "/R6 left"}, got_l[i], el);
        check(got_r[i] == er, {req, "/R6 right"}, got_r[i], er);
      end
    end
  endtask

  initial begin
    #3;
    @(negedge clk);
    check(left_o == '0 && right_o == '0, "R1 outputs in reset", left_o | right_o, 24'd0);
    check(valid_o == 1'b0, "R1 strobe in reset", 24'(valid_o), 24'd0);
    rst_ni = 1'b1;
    repeat (10) @(posedge clk);
    @(negedge clk);
    check(valid_o == 1'b0 && left_o == '0, "R1 idle after reset", 24'(valid_o) | left_o, 24'd0);
    for (int m = 0; m < 4; m++)
      for (int sel = 0; sel < 4; sel++)
        run_cfg(m, sel, 33);
    for (int m = 0; m < 4; m++) run_cfg(m, 3, 17);
    check(wide_pulse == 0, "R7 strobe width", 24'(wide_pulse), 24'd0);
    check(hold_viol == 0, "R8 outputs held between strobes", 24'(hold_viol), 24'd0);
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule